// File: doc/BRIEF.md
# DDR Read/Write Burst Sequencer

The sequencer sits between a simple request port and the command and data pins of a DDR2/DDR3-style memory. It takes one read or one write request at a time. For each request it puts one column command on the command bus. It then counts the access latency and either drives the write burst, with its per-byte masks, or captures the read burst and hands each beat back to the host with a valid strobe. Row activation, refresh and strobe generation are handled elsewhere. Data is modelled as one beat per controller clock.

The host presents a request with `reqValid` while `reqReady` is high. A write request carries the whole burst of data and byte enables. The latency (`cfgCl`) and the burst length (`cfgBl8`) are taken when the request is accepted. Call the cycle right after the accepting clock edge C0. The command appears on the bus in C0. The data beats start at C0+L, where L is the CAS latency for a read and one cycle less for a write. A one-cycle `done` pulse follows the last beat.

Top module: `ddr_burst_seq`

## Requirements
- R1: When no command is issued, the command bus shows NOP: `cmdRasN`=1, `cmdCasN`=1, `cmdWeN`=1, and `cmdAddr` is 0.
- R2: A read request accepted at a clock edge puts a read command (`cmdRasN`=1, `cmdCasN`=0, `cmdWeN`=1) on the bus for exactly one cycle, C0, with `cmdAddr` equal to the request address.
- R3: An accepted write request puts a write command (`cmdRasN`=1, `cmdCasN`=0, `cmdWeN`=0) on the bus for exactly one cycle, C0, with `cmdAddr` equal to the request address.
- R4: For a read with latency CL, `dqIn` is sampled at the clock edge that ends cycle C0+CL+i, for beats i=0..BL-1. Each sample is returned on `rdData` with `rdValid`=1 in the following cycle, in beat order. `rdValid` is 0 in every other cycle.
- R5: For a write, beat i is driven on `dqOut` with `dqOe`=1 in cycle C0+(CL-1)+i. Beat i is `reqWdata[i*16 +: 16]`. `dqOe` is 0 in every cycle that carries no write beat.
- R6: During write beat i, `dqm` equals the bitwise inverse of `reqBe[i*2 +: 2]`. A byte enable of 1 means the byte is written, and a `dqm` bit of 1 masks that byte. Outside write beats, including whole read bursts, `dqm` is 0.
- R7: `cfgBl8`=1 selects a burst of 8 beats and `cfgBl8`=0 selects a burst of 4 beats.
- R8: `reqReady` is 1 only while no burst is pending or in progress. A request held valid during a burst issues no command. `done` is high for exactly one cycle, C0+L+BL, and `reqReady` is high again from that cycle on.
- R9: `cfgCl` and `cfgBl8` are sampled when a request is accepted. Changing them later has no effect on that burst.
- R10: A `cfgCl` value below 2 is treated as 2, so the write latency never drops below 1.
- R11: A synchronous active-high `rst` returns the sequencer to idle in the cycle after the edge, even in the middle of a burst. In that state the bus shows NOP, `dqOe`=0, `dqm`=0, `rdValid`=0, `done`=0 and `reqReady`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (14) | Column/bank address for the command |
| reqWdata | input | MAX_BL*DQ_W (128) | Write burst, beat i at bits i*DQ_W upward |
| reqBe | input | MAX_BL*DQ_W/8 (16) | Byte enables per beat, 1 = write byte |
| cfgCl | input | CL_W (4) | CAS latency |
| cfgBl8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| cmdAddr | output | ADDR_W (14) | Address during the command cycle |
| dqOut | output | DQ_W (16) | Write data beat |
| dqOe | output | 1 | Data output enable |
| dqm | output | DQ_W/8 (2) | Byte mask, 1 = byte masked |
| dqIn | input | DQ_W (16) | Read data from the pins |
| rdValid | output | 1 | Read beat valid on rdData |
| rdData | output | DQ_W (16) | Captured read beat |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The hardest situation to reach is a burst whose configuration is altered while it is in flight. It matters most when the burst length shrinks from 8 to 4 and the latency moves at the same time. The bench reaches it by changing `cfgCl` and `cfgBl8` in the command cycle, just after acceptance. It then checks every later cycle against the timing implied by the values sampled at acceptance. A request held valid across a whole burst, and a reset landing in the middle of the write beats, are driven the same way: the bench changes the inputs at chosen cycles relative to the accepting edge.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int MAX_BL = 8;
  localparam int BIDX_W = $clog2(MAX_BL);
  localparam int BL_W   = BIDX_W + 1;

  // Strobes from the control to the datapath, valid in the current cycle.
  typedef struct packed {
    logic              accept;   // request taken at the coming edge
    logic              cmdEn;    // column command on the bus this cycle
    logic              isWrite;  // burst in flight is a write
    logic              beatEn;   // a data beat occupies this cycle
    logic [BIDX_W-1:0] beatIdx;  // which beat of the burst
  } seqStb_t;

endpackage

// File: rtl/ddr_seq_ctrl.sv
module ddr_seq_ctrl
  import ddr_seq_pkg::*;
#(
  parameter int CL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [CL_W-1:0] cfgCl,
  input  logic            cfgBl8,
  output logic            reqReady,
  output logic            done,
  output seqStb_t         stb
);

  localparam int MAX_CL = (1 << CL_W) - 1;
  localparam int CYC_W  = $clog2(MAX_CL + MAX_BL + 1);

  logic            busy;
  logic            isWriteQ;
  logic [CYC_W-1:0] cyc;
  logic [CL_W-1:0] latQ;
  logic [BL_W-1:0] blQ;

  logic            accept;
  logic [CL_W-1:0] clClamped;
  logic [CL_W-1:0] latNext;
  logic [BL_W-1:0] blNext;
  logic [CYC_W-1:0] latExt;
  logic [CYC_W-1:0] endCyc;
  logic            beatEn;
  logic            lastBeat;

  assign accept    = reqValid && !busy;
  assign reqReady  = !busy;

  // Latency floor keeps the write data at least one cycle after the command.
  assign clClamped = (cfgCl < CL_W'(2)) ? CL_W'(2) : cfgCl;
  assign latNext   = reqWrite ? (clClamped - CL_W'(1)) : clClamped;
  assign blNext    = cfgBl8 ? BL_W'(MAX_BL) : BL_W'(MAX_BL / 2);

  assign latExt    = CYC_W'(latQ);
  assign endCyc    = latExt + CYC_W'(blQ) - CYC_W'(1);
  assign beatEn    = busy && (cyc >= latExt) && (cyc <= endCyc);
  assign lastBeat  = busy && (cyc == endCyc);

  always_comb begin
    stb.accept  = accept;
    stb.cmdEn   = busy && (cyc == '0);
    stb.isWrite = isWriteQ;
    stb.beatEn  = beatEn;
    stb.beatIdx = BIDX_W'(cyc - latExt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      isWriteQ <= 1'b0;
      cyc      <= '0;
      latQ     <= '0;
      blQ      <= '0;
      done     <= 1'b0;
    end else begin
      done <= lastBeat;
      if (accept) begin
        busy     <= 1'b1;
        isWriteQ <= reqWrite;
        cyc      <= '0;
        latQ     <= latNext;
        blQ      <= blNext;
      end else if (busy) begin
        if (lastBeat) begin
          busy <= 1'b0;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ddr_seq_dp.sv
module ddr_seq_dp
  import ddr_seq_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int ADDR_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStb_t                  stb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [MAX_BL*DQ_W-1:0]   reqWdata,
  input  logic [MAX_BL*DQ_W/8-1:0] reqBe,
  input  logic [DQ_W-1:0]          dqIn,
  output logic                     cmdRasN,
  output logic                     cmdCasN,
  output logic                     cmdWeN,
  output logic [ADDR_W-1:0]        cmdAddr,
  output logic [DQ_W-1:0]          dqOut,
  output logic                     dqOe,
  output logic [DQ_W/8-1:0]        dqm,
  output logic                     rdValid,
  output logic [DQ_W-1:0]          rdData
);

  localparam int MASK_W = DQ_W / 8;

  logic [DQ_W-1:0]   wBeatIn [MAX_BL];
  logic [MASK_W-1:0] beIn    [MAX_BL];
  logic [DQ_W-1:0]   wBeatQ  [MAX_BL];
  logic [MASK_W-1:0] beQ     [MAX_BL];
  logic [ADDR_W-1:0] addrQ;
  logic              wrBeat;
  logic              rdBeat;

  // Each beat slot holds its own data and byte enables from acceptance on.
  for (genvar g = 0; g < MAX_BL; g++) begin : g_beat
    assign wBeatIn[g] = reqWdata[g*DQ_W +: DQ_W];
    assign beIn[g]    = reqBe[g*MASK_W +: MASK_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        wBeatQ[g] <= '0;
        beQ[g]    <= '0;
      end else if (stb.accept) begin
        wBeatQ[g] <= wBeatIn[g];
        beQ[g]    <= beIn[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
    end else if (stb.accept) begin
      addrQ <= reqAddr;
    end
  end

  assign wrBeat  = stb.beatEn && stb.isWrite;
  assign rdBeat  = stb.beatEn && !stb.isWrite;

  // Only column commands are issued; the row strobe stays high.
  assign cmdRasN = 1'b1;
  assign cmdCasN = !stb.cmdEn;
  assign cmdWeN  = !(stb.cmdEn && stb.isWrite);
  assign cmdAddr = stb.cmdEn ? addrQ : '0;

  assign dqOe    = wrBeat;
  assign dqOut   = wrBeat ? wBeatQ[stb.beatIdx] : '0;
  assign dqm     = wrBeat ? ~beQ[stb.beatIdx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdBeat;
      if (rdBeat) begin
        rdData <= dqIn;
      end
    end
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int ADDR_W = 14,
  parameter int CL_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [MAX_BL*DQ_W-1:0]   reqWdata,
  input  logic [MAX_BL*DQ_W/8-1:0] reqBe,
  input  logic [CL_W-1:0]          cfgCl,
  input  logic                     cfgBl8,
  output logic                     cmdRasN,
  output logic                     cmdCasN,
  output logic                     cmdWeN,
  output logic [ADDR_W-1:0]        cmdAddr,
  output logic [DQ_W-1:0]          dqOut,
  output logic                     dqOe,
  output logic [DQ_W/8-1:0]        dqm,
  input  logic [DQ_W-1:0]          dqIn,
  output logic                     rdValid,
  output logic [DQ_W-1:0]          rdData,
  output logic                     done
);

  seqStb_t stb;

  ddr_seq_ctrl #(
    .CL_W(CL_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .cfgCl    (cfgCl),
    .cfgBl8   (cfgBl8),
    .reqReady (reqReady),
    .done     (done),
    .stb      (stb)
  );

  ddr_seq_dp #(
    .DQ_W   (DQ_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .dqIn     (dqIn),
    .cmdRasN  (cmdRasN),
    .cmdCasN  (cmdCasN),
    .cmdWeN   (cmdWeN),
    .cmdAddr  (cmdAddr),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .dqm      (dqm),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ddr_seq_chk.sv
module ddr_seq_chk #(
  parameter int MASK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              cmdRasN,
  input logic              cmdCasN,
  input logic              cmdWeN,
  input logic              dqOe,
  input logic [MASK_W-1:0] dqm,
  input logic              rdValid,
  input logic              done
);

  logic inRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      inRead <= 1'b0;
    end else if (reqValid && reqReady) begin
      inRead <= !reqWrite;
    end else if (done) begin
      inRead <= 1'b0;
    end
  end

  // R2, R3: command right after acceptance with the requested direction
  a_r2_cmd_after_accept: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (cmdRasN && !cmdCasN && (cmdWeN == !$past(reqWrite))));

  // R8: command lasts a single cycle
  a_r8_cmd_single: assert property (@(posedge clk) disable iff (rst)
    !cmdCasN |=> cmdCasN);

  // R8: not ready once a request has been taken
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: idle bus shows NOP
  a_r1_idle_nop: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (cmdRasN && cmdCasN && cmdWeN));

  // R6: reads neither drive the pins nor mask bytes
  a_r6_read_no_mask: assert property (@(posedge clk) disable iff (rst)
    inRead |-> (!dqOe && (dqm == '0)));

  // R4: read beats come back only during a read
  a_r4_rdvalid_in_read: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> inRead);

  // R5: output enable only while not idle
  a_r5_oe_busy: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> !reqReady);

endmodule

bind ddr_burst_seq ddr_seq_chk #(
  .MASK_W(DQ_W / 8)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .cmdRasN  (cmdRasN),
  .cmdCasN  (cmdCasN),
  .cmdWeN   (cmdWeN),
  .dqOe     (dqOe),
  .dqm      (dqm),
  .rdValid  (rdValid),
  .done     (done)
);

// File: tb/ddr_burst_seq_tb.sv
module ddr_burst_seq_tb;

  localparam int DQ_W   = 16;
  localparam int ADDR_W = 14;
  localparam int CL_W   = 4;
  localparam int NB     = 8;
  localparam int MW     = DQ_W / 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic                reqWrite = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [NB*DQ_W-1:0]  reqWdata = '0;
  logic [NB*MW-1:0]    reqBe = '0;
  logic [CL_W-1:0]     cfgCl = 4'd3;
  logic                cfgBl8 = 1'b1;
  logic                cmdRasN, cmdCasN, cmdWeN;
  logic [ADDR_W-1:0]   cmdAddr;
  logic [DQ_W-1:0]     dqOut;
  logic                dqOe;
  logic [MW-1:0]       dqm;
  logic [DQ_W-1:0]     dqIn = '0;
  logic                rdValid;
  logic [DQ_W-1:0]     rdData;
  logic                done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr_burst_seq #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .CL_W(CL_W)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .cfgCl(cfgCl), .cfgBl8(cfgBl8), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN),
    .cmdWeN(cmdWeN), .cmdAddr(cmdAddr), .dqOut(dqOut), .dqOe(dqOe), .dqm(dqm),
    .dqIn(dqIn), .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DQ_W-1:0] pat(input int k, input logic [ADDR_W-1:0] a);
    return 16'hA55A ^ 16'(k * 16'h0123) ^ 16'(a);
  endfunction

  function automatic logic [NB*DQ_W-1:0] mkData(input logic [DQ_W-1:0] seed);
    logic [NB*DQ_W-1:0] w;
    for (int i = 0; i < NB; i++) w[i*DQ_W +: DQ_W] = seed ^ 16'(i * 16'h1111);
    return w;
  endfunction

  task automatic checkIdle(input string tag);
    chk({cmdRasN, cmdCasN, cmdWeN} == 3'b111, tag, {cmdRasN, cmdCasN, cmdWeN}, 3'b111);
    chk(dqOe == 1'b0 && dqm == '0, tag, {dqOe, dqm}, 0);
    chk(rdValid == 1'b0 && done == 1'b0, tag, {rdValid, done}, 0);
    chk(reqReady == 1'b1, tag, reqReady, 1);
  endtask

  // One burst, checked cycle by cycle from the command cycle (k=0) onward.
  task automatic runBurst(input bit isW, input int cl, input bit bl8,
                          input logic [ADDR_W-1:0] addr, input logic [NB*DQ_W-1:0] wd,
                          input logic [NB*MW-1:0] be, input bit keepValid, input bit midChange);
    int clc, lat, bl;
    bit beat, rdBeatPrev;
    int i;
    clc = (cl < 2) ? 2 : cl;
    lat = isW ? clc - 1 : clc;
    bl  = bl8 ? 8 : 4;
    @(negedge clk);
    chk(reqReady, "R8 ready before request", reqReady, 1);
    reqWrite = isW; reqAddr = addr; reqWdata = wd; reqBe = be;
    cfgCl = 4'(cl); cfgBl8 = bl8; reqValid = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= lat + bl + 1; k++) begin
      @(negedge clk);
      if (k == 0 && !keepValid) reqValid = 1'b0;
      if (k == 0 && midChange) begin
        cfgCl = 4'd9; cfgBl8 = ~bl8;
      end
      if (k == 0) begin
        chk(cmdRasN && !cmdCasN && (cmdWeN == !isW), isW ? "R3 write cmd" : "R2 read cmd",
            {cmdRasN, cmdCasN, cmdWeN}, {2'b10, !isW});
        chk(cmdAddr == addr, isW ? "R3 cmd addr" : "R2 cmd addr", cmdAddr, addr);
      end else begin
        chk({cmdRasN, cmdCasN, cmdWeN} == 3'b111 && cmdAddr == '0, "R1 nop", {cmdRasN, cmdCasN, cmdWeN}, 3'b111);
      end
      beat = (k >= lat) && (k < lat + bl);
      i = k - lat;
      chk(dqOe == (isW && beat), "R5 oe", dqOe, isW && beat);
      if (isW && beat) begin
        chk(dqOut == wd[i*DQ_W +: DQ_W], "R5 write data", dqOut, wd[i*DQ_W +: DQ_W]);
        chk(dqm == ~be[i*MW +: MW], "R6 mask aligned", dqm, ~be[i*MW +: MW]);
      end else begin
        chk(dqm == '0, "R6 mask inactive", dqm, 0);
      end
      rdBeatPrev = !isW && (k - 1 >= lat) && (k - 1 < lat + bl);
      chk(rdValid == rdBeatPrev, "R4 rdValid", rdValid, rdBeatPrev);
      if (rdBeatPrev) chk(rdData == pat(k - 1, addr), "R4 rdData", rdData, pat(k - 1, addr));
      chk(done == (k == lat + bl), "R8 done", done, k == lat + bl);
      chk(reqReady == (k >= lat + bl), midChange ? "R9 length kept" : "R7 ready", reqReady, k >= lat + bl);
      if (k == lat + bl) reqValid = 1'b0;
      dqIn = pat(k, addr);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    checkIdle("R11 reset state");
    rst = 1'b0;
  endtask

  task automatic t_read_basic;
    runBurst(1'b0, 3, 1'b1, 14'h0123, '0, '0, 1'b0, 1'b0);     // R2 R4 R7
  endtask

  task automatic t_write_basic;
    runBurst(1'b1, 3, 1'b0, 14'h2AB0, mkData(16'h1357), 16'b00_00_00_00_10_01_00_11, 1'b0, 1'b0); // R3 R5 R6
    runBurst(1'b1, 3, 1'b1, 14'h0777, mkData(16'hC0DE), 16'b11_01_10_00_01_10_11_00, 1'b0, 1'b0); // R7
  endtask

  task automatic t_long_latency;
    runBurst(1'b0, 6, 1'b0, 14'h1111, '0, '0, 1'b0, 1'b0);     // R4 R7
    runBurst(1'b1, 7, 1'b0, 14'h0A0A, mkData(16'h00FF), 16'hA5C3, 1'b0, 1'b0);
  endtask

  task automatic t_clamp;
    runBurst(1'b1, 0, 1'b0, 14'h0042, mkData(16'hBEEF), 16'h3C96, 1'b0, 1'b0); // R10
    runBurst(1'b0, 1, 1'b0, 14'h0043, '0, '0, 1'b0, 1'b0);                     // R10
  endtask

  task automatic t_cfg_change;
    runBurst(1'b0, 3, 1'b1, 14'h3001, '0, '0, 1'b0, 1'b1);                     // R9
    runBurst(1'b1, 2, 1'b1, 14'h3002, mkData(16'h5A5A), 16'hF00F, 1'b0, 1'b1); // R9
  endtask

  task automatic t_hold_valid;
    runBurst(1'b1, 4, 1'b0, 14'h1F1F, mkData(16'h7777), 16'hFFFF, 1'b1, 1'b0); // R8
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 14'h0555; reqWdata = mkData(16'h4242); reqBe = 16'h0F0F;
    cfgCl = 4'd3; cfgBl8 = 1'b1; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk); reqValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(dqOe == 1'b1, "R11 burst running", dqOe, 1);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R11 reset mid-burst");
    rst = 1'b0;
    runBurst(1'b0, 3, 1'b0, 14'h0556, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_read_basic();
    t_write_basic();
    t_long_latency();
    t_clamp();
    t_cfg_change();
    t_hold_valid();
    t_reset_mid();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule